// File: doc/BRIEF.md
# Floating-point control and status register file

This block keeps the 32-bit floating-point control word (rounding mode, sticky exception flags, trap enables, last-operation cause, flush-to-zero and eight condition codes) and a read-only implementation/revision constant. Software reaches this state through a 5-bit control-register index. The full-word index shows the whole word. Three compact indices show repacked subsets of it, so that code can touch only the condition codes, only the exception fields, or only the mode fields.

The arithmetic datapath reports each operation's exception outcome on a status-update port. The block replaces the cause field with it, merges it into the sticky flags and decides whether a floating-point trap is due. Writes to the indices that can change cause or enables also re-check the trap condition. The trap output is a one-cycle pulse in the cycle after the event that raised it. Reads are combinational and return 64-bit data sign-extended from the 32-bit view.

Top module: `fpu_ctl_regs`

## Requirements
- R1: After reset the word is all zero, so rounding mode is round-to-nearest (0), and trap_o is low.
- R2: Index 31 reads and writes the whole word. Bits 22:18 always read zero and never store a one. The word layout is: rounding mode 1:0, flags 6:2, enables 11:7, cause 17:12, condition code 0 at bit 23, flush-to-zero at bit 24, condition codes 1 to 7 at bits 31:25.
- R3: Index 25 reads the eight condition codes as bits 7:0 (code n at bit n) with the rest zero. A write to index 25 stores data bits 7:0 back into the same codes and changes nothing else.
- R4: Index 26 reads cause (17:12) and flags (6:2) in place with all other bits zero. A write to index 26 updates only those two fields.
- R5: Index 28 reads enables (11:7) and rounding mode (1:0) in place, with flush-to-zero shown at bit 2. A write to index 28 sets those three fields and leaves condition codes, cause and flags unchanged.
- R6: Index 0 returns the implementation value given by parameter IMPL_VAL, and writes to index 0 have no effect.
- R7: Reads of any index other than 0, 25, 26, 28 and 31 return zero, and writes to them have no effect.
- R8: Read data bits 63:32 all equal bit 31 of the selected 32-bit view.
- R9: After a write to index 26, 28 or 31, trap_o pulses high for exactly the next cycle if (cause bits 4:0 AND enables) is nonzero or cause bit 5 (unimplemented) is set. A write to index 25 never raises trap_o. Exception bit order is inexact 0, underflow 1, overflow 2, divide-by-zero 3, invalid 4.
- R10: A status update replaces the whole cause field with the 6 reported bits, ORs bits 4:0 into the sticky flags and excludes the unimplemented bit from the flags. It then raises trap_o on the same condition as R9, and an unimplemented cause traps whatever the enables are.
- R11: When a write and a status update arrive in the same cycle, the write is applied first and the status update is applied on top of its result, and the trap check uses the combined word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_idx_i | input | 5 | Control-register index to read |
| rd_data_o | output | DATA_W | Sign-extended read data |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 5 | Control-register index to write |
| wr_data_i | input | 32 | Write data |
| st_en_i | input | 1 | Status-update strobe |
| st_cause_i | input | 6 | Reported exception cause bits |
| trap_o | output | 1 | Floating-point trap pulse |

## Verification
The bench targets the gap between condition code 0 and code 1. A design that packed the codes contiguously would move codes 1 to 7 onto the flush-to-zero bit and give wrong index-25 reads. It drives writes to index 28 while cause and flags are set, because a mask that is too wide there silently clears sticky history. It sends unimplemented causes with every enable off, which a design that only ANDs cause with enables would never trap. It also checks that such a cause never lands in the flags. Simultaneous write and status-update cycles show whether the update is layered on the written word or lost.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned CAUSE_W = 6;
  localparam int unsigned EXC_W   = 5;
  localparam int unsigned NUM_CC  = 8;

  localparam int unsigned FLAG_LSB  = 2;
  localparam int unsigned ENA_LSB   = 7;
  localparam int unsigned CAUSE_LSB = 12;
  localparam int unsigned CC0_BIT   = 23;
  localparam int unsigned FS_BIT    = 24;
  localparam int unsigned CCN_BASE  = 24;
  localparam int unsigned UNIMPL    = 5;

  localparam logic [IDX_W-1:0] IX_IMPL = 5'd0;
  localparam logic [IDX_W-1:0] IX_CC   = 5'd25;
  localparam logic [IDX_W-1:0] IX_EXC  = 5'd26;
  localparam logic [IDX_W-1:0] IX_MODE = 5'd28;
  localparam logic [IDX_W-1:0] IX_ALL  = 5'd31;

  localparam logic [WORD_W-1:0] M_RSVD = 32'h007C_0000;
  localparam logic [WORD_W-1:0] M_EXC  = 32'h0003_F07C;  // cause + flags
  localparam logic [WORD_W-1:0] M_MODE = 32'h0000_0F83;  // enables + rounding
  localparam logic [WORD_W-1:0] M_KEEP = 32'hFE83_F07C;  // kept by a mode write

  // condition code n sits at bit 23 for n=0, else 24+n (hole at 24)
  function automatic int unsigned cc_pos(int unsigned n);
    return (n == 0) ? CC0_BIT : CCN_BASE + n;
  endfunction
endpackage

// File: rtl/fcsr_rd_view.sv
module fcsr_rd_view
  import fcsr_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] impl_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] data_o
);
  logic [NUM_CC-1:0] cc_pack;
  logic [WORD_W-1:0] view;

  for (genvar g = 0; g < NUM_CC; g++) begin : g_cc
    assign cc_pack[g] = word_i[cc_pos(g)];
  end

  always_comb begin
    view = '0;
    unique case (idx_i)
      IX_IMPL: view = impl_i;
      IX_CC:   view[NUM_CC-1:0] = cc_pack;
      IX_EXC:  view = word_i & M_EXC;
      IX_MODE: begin
        view    = word_i & M_MODE;
        view[2] = word_i[FS_BIT];
      end
      IX_ALL:  view = word_i & ~M_RSVD;
      default: view = '0;
    endcase
  end

  if (DATA_W > WORD_W) begin : g_sext
    assign data_o = {{(DATA_W-WORD_W){view[WORD_W-1]}}, view};
  end else begin : g_flat
    assign data_o = view[DATA_W-1:0];
  end
endmodule

// File: rtl/fcsr_wr_merge.sv
module fcsr_wr_merge
  import fcsr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              check_o
);
  logic [WORD_W-1:0] cc_spread;

  always_comb begin
    cc_spread = word_i;
    for (int i = 0; i < NUM_CC; i++) cc_spread[cc_pos(i)] = data_i[i];
  end

  always_comb begin
    word_o  = word_i;
    check_o = 1'b0;
    if (en_i) begin
      unique case (idx_i)
        IX_CC:  word_o = cc_spread;
        IX_EXC: begin
          word_o  = (word_i & ~M_EXC) | (data_i & M_EXC);
          check_o = 1'b1;
        end
        IX_MODE: begin
          word_o         = (word_i & M_KEEP) | (data_i & M_MODE);
          word_o[FS_BIT] = data_i[2];
          check_o        = 1'b1;
        end
        IX_ALL: begin
          word_o  = data_i & ~M_RSVD;
          check_o = 1'b1;
        end
        default: word_o = word_i;
      endcase
    end
  end
endmodule

// File: rtl/fcsr_status_merge.sv
module fcsr_status_merge
  import fcsr_pkg::*;
(
  input  logic [WORD_W-1:0]  word_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               en_i,
  output logic [WORD_W-1:0]  word_o
);
  always_comb begin
    word_o = word_i;
    if (en_i) begin
      word_o[CAUSE_LSB +: CAUSE_W] = cause_i;
      // unimplemented never becomes sticky
      word_o[FLAG_LSB +: EXC_W] = word_i[FLAG_LSB +: EXC_W] | cause_i[EXC_W-1:0];
    end
  end
endmodule

// File: rtl/fcsr_trap_eval.sv
module fcsr_trap_eval
  import fcsr_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [EXC_W-1:0]   ena_i,
  output logic               trap_o
);
  assign trap_o = (|(cause_i[EXC_W-1:0] & ena_i)) | cause_i[UNIMPL];
endmodule

// File: rtl/fpu_ctl_regs.sv
module fpu_ctl_regs
  import fcsr_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter logic [31:0] IMPL_VAL = 32'h0000_0A11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic               st_en_i,
  input  logic [CAUSE_W-1:0] st_cause_i,
  output logic               trap_o
);
  logic [WORD_W-1:0] word_q, wr_word, st_word;
  logic              wr_chk, trap_hit, trap_q;

  fcsr_wr_merge u_wr (
    .word_i (word_q),
    .idx_i  (wr_idx_i),
    .data_i (wr_data_i),
    .en_i   (wr_en_i),
    .word_o (wr_word),
    .check_o(wr_chk)
  );

  // status update layered on top of a same-cycle write
  fcsr_status_merge u_st (
    .word_i (wr_word),
    .cause_i(st_cause_i),
    .en_i   (st_en_i),
    .word_o (st_word)
  );

  fcsr_trap_eval u_trap (
    .cause_i(st_word[CAUSE_LSB +: CAUSE_W]),
    .ena_i  (st_word[ENA_LSB +: EXC_W]),
    .trap_o (trap_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      trap_q <= 1'b0;
    end else begin
      word_q <= st_word;
      trap_q <= (wr_chk | st_en_i) & trap_hit;
    end
  end

  fcsr_rd_view #(.DATA_W(DATA_W)) u_rd (
    .word_i(word_q),
    .impl_i(IMPL_VAL),
    .idx_i (rd_idx_i),
    .data_o(rd_data_o)
  );

  assign trap_o = trap_q;
endmodule

// File: rtl/fcsr_chk.sv
module fcsr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [4:0]  wr_idx_i,
  input logic        st_en_i,
  input logic [5:0]  st_cause_i,
  input logic [31:0] word_i,
  input logic        trap_i
);
  logic listed, trap_idx;
  assign listed   = (wr_idx_i == 5'd25) || (wr_idx_i == 5'd26) ||
                    (wr_idx_i == 5'd28) || (wr_idx_i == 5'd31);
  assign trap_idx = (wr_idx_i == 5'd26) || (wr_idx_i == 5'd28) || (wr_idx_i == 5'd31);

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_i[22:18] == 5'd0);

  p_cc_write_local_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_idx_i == 5'd25 && !st_en_i
    |=> word_i[22:0] == $past(word_i[22:0]) && word_i[24] == $past(word_i[24]) && !trap_i);

  p_mode_write_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_idx_i == 5'd28 && !st_en_i
    |=> word_i[31:25] == $past(word_i[31:25]) && word_i[23] == $past(word_i[23]) &&
        word_i[17:12] == $past(word_i[17:12]) && word_i[6:2] == $past(word_i[6:2]));

  p_unlisted_noeffect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !listed && !st_en_i |=> $stable(word_i) && !trap_i);

  p_trap_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |-> $past(st_en_i || (wr_en_i && trap_idx)));

  p_unimpl_traps_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_en_i && st_cause_i[5] |=> trap_i);

  p_flags_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_en_i && !wr_en_i
    |=> (word_i[6:2] & $past(word_i[6:2])) == $past(word_i[6:2]) && word_i[17:12] == $past(st_cause_i));
endmodule

bind fpu_ctl_regs fcsr_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_idx_i  (wr_idx_i),
  .st_en_i   (st_en_i),
  .st_cause_i(st_cause_i),
  .word_i    (word_q),
  .trap_i    (trap_o)
);

// File: tb/fpu_ctl_regs_tb.sv
`timescale 1ns/1ps
module fpu_ctl_regs_tb;
  localparam logic [31:0] IMPL = 32'h0000_0A11;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_idx = 5'd31;
  logic [63:0] rd_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        st_en = 1'b0;
  logic [5:0]  st_cause = '0;
  logic        trap;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_word = '0;
  logic        m_trap = 1'b0;

  fpu_ctl_regs #(.DATA_W(64), .IMPL_VAL(IMPL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .st_en_i(st_en), .st_cause_i(st_cause), .trap_o(trap)
  );

  always #2.5 clk = ~clk;

  function automatic logic [63:0] m_read(logic [31:0] w, logic [4:0] ix);
    logic [31:0] v = 32'd0;
    if (ix == 0) v = IMPL;
    else if (ix == 25) begin
      v[0] = w[23];
      for (int n = 1; n < 8; n++) v[n] = w[24 + n];
    end
    else if (ix == 26) v = w & 32'h0003_F07C;
    else if (ix == 28) v = (w & 32'h0000_0F83) | (32'(w[24]) << 2);
    else if (ix == 31) v = w;
    return {{32{v[31]}}, v};
  endfunction

  function automatic bit m_traps(logic [31:0] w);
    return ((w[16:12] & w[11:7]) != 0) || w[17];
  endfunction

  function automatic string req_of(logic [4:0] ix);
    case (ix)
      5'd0: return "R6";
      5'd25: return "R3";
      5'd26: return "R4";
      5'd28: return "R5";
      5'd31: return "R2";
      default: return "R7";
    endcase
  endfunction

  task automatic check_now(string tag);
    logic [63:0] exp = m_read(m_word, rd_idx);
    string t = (tag == "") ? req_of(rd_idx) : tag;
    checks++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s idx=%0d read actual=%h expected=%h", t, rd_idx, rd_data, exp);
    end
    checks++;
    if (trap !== m_trap) begin
      bad++;
      $display("FAIL R9 trap (%s) actual=%b expected=%b", t, trap, m_trap);
    end
  endtask

  // drive one cycle, advance model, check after the edge
  task automatic cyc(input logic [4:0] ri, input bit we, input logic [4:0] wi,
                     input logic [31:0] wd, input bit se, input logic [5:0] sc,
                     input string tag);
    logic [31:0] w = m_word;
    bit chk = 0;
    rd_idx = ri; wr_en = we; wr_idx = wi; wr_data = wd; st_en = se; st_cause = sc;
    if (we) begin
      if (wi == 25) begin
        w[23] = wd[0];
        for (int n = 1; n < 8; n++) w[24 + n] = wd[n];
      end else if (wi == 26) begin
        w = (w & ~32'h0003_F07C) | (wd & 32'h0003_F07C); chk = 1;
      end else if (wi == 28) begin
        w = (w & 32'hFE83_F07C) | (wd & 32'h0000_0F83); w[24] = wd[2]; chk = 1;
      end else if (wi == 31) begin
        w = wd & ~32'h007C_0000; chk = 1;
      end
    end
    if (se) begin
      w[17:12] = sc;
      w[6:2]   = w[6:2] | sc[4:0];
      chk = 1;
    end
    m_word = w;
    m_trap = chk && m_traps(w);
    @(posedge clk);
    @(negedge clk);
    check_now(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    check_now("R1");
    rd_idx = 5'd28; #0.1 check_now("R1");
    rd_idx = 5'd25; #0.1 check_now("R1");

    // R2 full word, reserved bits dropped; also R8 with top bit set
    cyc(5'd31, 1, 5'd31, 32'hFFFF_FFFF, 0, '0, "R2");
    cyc(5'd31, 1, 5'd31, 32'h8000_0001, 0, '0, "R8");
    cyc(5'd25, 0, 5'd0, '0, 0, '0, "R3");
    // R6 write ignored
    cyc(5'd0, 1, 5'd0, 32'h1234_5678, 0, '0, "R6");
    cyc(5'd31, 0, 5'd0, '0, 0, '0, "R6");
    // R3 condition-code packing across the hole
    cyc(5'd25, 1, 5'd25, 32'h0000_00A5, 0, '0, "R3");
    cyc(5'd31, 1, 5'd25, 32'hFFFF_FF5A, 0, '0, "R3");
    cyc(5'd25, 1, 5'd25, 32'h0000_0080, 0, '0, "R8");
    // R4 exception view
    cyc(5'd26, 1, 5'd26, 32'hFFFF_FFFF, 0, '0, "R4");
    cyc(5'd31, 1, 5'd26, 32'h0000_0000, 0, '0, "R4");
    // R5 mode view keeps codes, cause and flags
    cyc(5'd31, 1, 5'd31, 32'hFE83_F07C, 0, '0, "R5");
    cyc(5'd28, 1, 5'd28, 32'hFFFF_F07F, 0, '0, "R5");
    cyc(5'd31, 1, 5'd28, 32'h0000_0004, 0, '0, "R5");
    // R7 unlisted indices
    cyc(5'd30, 1, 5'd30, 32'hFFFF_FFFF, 0, '0, "R7");
    cyc(5'd1, 1, 5'd27, 32'hFFFF_FFFF, 0, '0, "R7");
    cyc(5'd31, 0, 5'd0, '0, 0, '0, "R7");
    // R9 trap from writes; index 25 never traps
    cyc(5'd28, 1, 5'd28, 32'h0000_0200, 0, '0, "R9");        // enable overflow
    cyc(5'd26, 1, 5'd26, 32'h0000_4000, 0, '0, "R9");        // cause overflow
    cyc(5'd26, 0, 5'd0, '0, 0, '0, "R9");
    cyc(5'd25, 1, 5'd25, 32'h0000_00FF, 0, '0, "R9");
    cyc(5'd28, 1, 5'd28, 32'h0000_0000, 0, '0, "R9");
    // R10 status updates
    cyc(5'd26, 0, 5'd0, '0, 1, 6'b100000, "R10");             // unimplemented, no enables
    cyc(5'd26, 0, 5'd0, '0, 1, 6'b000011, "R10");
    cyc(5'd28, 1, 5'd28, 32'h0000_0800, 0, '0, "R10");        // enable invalid
    cyc(5'd26, 0, 5'd0, '0, 1, 6'b010000, "R10");
    cyc(5'd26, 0, 5'd0, '0, 1, 6'b000000, "R10");
    // R11 simultaneous write and update
    cyc(5'd31, 1, 5'd31, 32'h0000_0000, 1, 6'b000101, "R11");
    cyc(5'd26, 1, 5'd26, 32'h0000_007C, 1, 6'b000010, "R11");
    cyc(5'd31, 1, 5'd28, 32'h0000_0080, 1, 6'b000001, "R11");

    for (int k = 0; k < 3000; k++) begin
      logic [4:0] pick[6] = '{5'd0, 5'd25, 5'd26, 5'd28, 5'd31, 5'd7};
      logic [4:0] ri = ($urandom % 4 == 0) ? 5'($urandom) : pick[$urandom % 6];
      logic [4:0] wi = ($urandom % 4 == 0) ? 5'($urandom) : pick[$urandom % 6];
      cyc(ri, ($urandom % 2) == 1, wi, $urandom, ($urandom % 3) == 0,
          6'($urandom) & (($urandom % 4 == 0) ? 6'h3F : 6'h1F), "");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule